// File: doc/BRIEF.md
# Command Slot Dispatch Scheduler

This block sits in front of a port's command engine and decides which posted command slot runs next. Software posts work by setting bits in a pending-slot bitmap. While the port run enable is on, the scheduler walks the slots from the lowest index upward. It offers one slot at a time to the engine through a valid/slot pair and waits for the engine's done strobe. A command that finishes at once has its pending bit removed, and the walk goes on.

A command can leave the device busy or holding a data request when it returns. Its slot is then parked in a busy-slot register and its pending bit is kept. No further slot is offered until an asynchronous completion strobe arrives and both device status lines are low. At that point the parked bit is removed, the park register empties, and a fresh pass starts from slot 0. A port reset empties the park register and leaves the pending bitmap as it is.

Top module: `slot_dispatch_sched`

## Requirements
- R1: No slot is offered while `run_en` is low. A pass starts only when `run_en` is high and the pending bitmap is nonzero.
- R2: Within a pass, pending slots are offered in ascending index order, 0 up to NSLOT-1. A pass ends after the last index, or earlier when the bitmap has become empty. A bit that arrives behind the scan position is offered in the next pass, which starts again from slot 0.
- R3: When `disp_done` is sampled high with `disp_async` low, the offered slot's bit in `issue_map` is cleared on that same edge, and `disp_valid` drops.
- R4: A pending slot examined while `dev_busy` or `dev_drq` is high is skipped and not offered. Its bit stays set.
- R5: When `disp_done` is sampled high with `disp_async` high, `busy_valid` goes high, `busy_slot` holds the slot index, and the slot's bit stays set.
- R6: While a slot is parked, an `async_cmpl` pulse with `dev_busy` and `dev_drq` both low clears the parked bit, drops `busy_valid` and starts a new pass from slot 0. An `async_cmpl` pulse with either status line high changes nothing.
- R7: A `port_reset` pulse drops `busy_valid` and returns the scheduler to idle. It clears no bit of `issue_map`.
- R8: A write with `issue_wr_en` ORs `issue_wr_mask` into the pending bitmap. It never clears a bit, including while a pass is running.
- R9: At most one slot is outstanding. No slot is offered while a slot is offered and not yet done, or while a slot is parked.
- R10: After `rst`, `issue_map` is zero and `disp_valid` and `busy_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_reset | input | 1 | Port reset pulse; empties the park register |
| run_en | input | 1 | Port run enable; gates scanning |
| issue_wr_en | input | 1 | Strobe that merges `issue_wr_mask` into the pending bitmap |
| issue_wr_mask | input | NSLOT | Slots to post (OR-merged) |
| dev_busy | input | 1 | Device busy status |
| dev_drq | input | 1 | Device data-request status |
| disp_done | input | 1 | Engine has finished handling the offered slot |
| disp_async | input | 1 | Qualifies `disp_done`: the command left the device busy |
| async_cmpl | input | 1 | Asynchronous completion notice for the parked slot |
| disp_valid | output | 1 | A slot is offered to the engine |
| disp_slot | output | SLOT_W | Index of the offered slot |
| busy_valid | output | 1 | A slot is parked |
| busy_slot | output | SLOT_W | Index of the parked slot |
| issue_map | output | NSLOT | Pending-slot bitmap |

## Verification
The properties assume that the engine raises `disp_done` only while `disp_valid` is high. They also assume that `async_cmpl` carries meaning only while a slot is parked, and that posted bits never name a slot index at or above NSLOT. The bench's engine model answers only an offered slot, after a fixed delay. It pulses completion and port reset only while the park register holds a slot. It changes the device status lines only at points where the expected dispatch order is already pushed into the scoreboard, so every offer can be predicted from the requirements.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2,
    ST_PARK = 2'd3
  } sched_state_e;
endpackage

// File: rtl/slot_issue_map.sv
// Pending-slot bitmap: OR-merge posts, single-bit clear from the scanner.
module slot_issue_map #(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NSLOT-1:0]  wr_mask,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_idx,
  output logic [NSLOT-1:0]  map_q
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_bit
    logic hit_clr;
    assign hit_clr = clr_en && (clr_idx == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        map_q[g] <= 1'b0;
      end else if (wr_en && wr_mask[g]) begin
        map_q[g] <= 1'b1;
      end else if (hit_clr) begin
        map_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slot_park_reg.sv
// Holds the index of a slot whose command is still running on the device.
module slot_park_reg #(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              park_set,
  input  logic [SLOT_W-1:0] park_idx,
  input  logic              park_clr,
  output logic              parked_q,
  output logic [SLOT_W-1:0] parked_idx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      parked_q     <= 1'b0;
      parked_idx_q <= '0;
    end else if (park_clr) begin
      parked_q     <= 1'b0;
    end else if (park_set) begin
      parked_q     <= 1'b1;
      parked_idx_q <= park_idx;
    end
  end
endmodule

// File: rtl/slot_scan_fsm.sv
// Ascending slot walker with a one-outstanding dispatch handshake.
module slot_scan_fsm
  import slot_sched_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_reset,
  input  logic              run_en,
  input  logic [NSLOT-1:0]  map_q,
  input  logic              dev_busy,
  input  logic              dev_drq,
  input  logic              disp_done,
  input  logic              disp_async,
  input  logic              async_cmpl,
  output logic              clr_en,
  output logic [SLOT_W-1:0] clr_idx,
  output logic              park_set,
  output logic              park_clr,
  output logic              disp_valid,
  output logic [SLOT_W-1:0] disp_slot
);
  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(NSLOT - 1);

  sched_state_e      st_q, st_n;
  logic [SLOT_W-1:0] idx_q, idx_n;
  logic              dv_q, dv_n;
  logic              dev_held;
  logic              at_last;

  assign dev_held = dev_busy | dev_drq;
  assign at_last  = (idx_q == LAST_IDX);

  always_comb begin
    st_n     = st_q;
    idx_n    = idx_q;
    dv_n     = dv_q;
    clr_en   = 1'b0;
    clr_idx  = idx_q;
    park_set = 1'b0;
    park_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (run_en && (map_q != '0)) begin
          st_n  = ST_SCAN;
          idx_n = '0;
        end
      end
      ST_SCAN: begin
        if (!run_en || (map_q == '0)) begin
          st_n = ST_IDLE;
        end else if (map_q[idx_q] && !dev_held) begin
          st_n = ST_WAIT;
          dv_n = 1'b1;
        end else if (at_last) begin
          st_n = ST_IDLE;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (disp_done) begin
          dv_n = 1'b0;
          if (disp_async) begin
            park_set = 1'b1;
            st_n     = ST_PARK;
          end else begin
            clr_en = 1'b1;
            if (at_last) begin
              st_n = ST_IDLE;
            end else begin
              st_n  = ST_SCAN;
              idx_n = idx_q + 1'b1;
            end
          end
        end
      end
      ST_PARK: begin
        if (async_cmpl && !dev_held) begin
          clr_en   = 1'b1;
          park_clr = 1'b1;
          st_n     = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (port_reset) begin
      st_n     = ST_IDLE;
      dv_n     = 1'b0;
      clr_en   = 1'b0;
      park_set = 1'b0;
      park_clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      dv_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
      dv_q  <= dv_n;
    end
  end

  assign disp_valid = dv_q;
  assign disp_slot  = idx_q;
endmodule

// File: rtl/slot_dispatch_sched.sv
module slot_dispatch_sched #(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_reset,
  input  logic              run_en,
  input  logic              issue_wr_en,
  input  logic [NSLOT-1:0]  issue_wr_mask,
  input  logic              dev_busy,
  input  logic              dev_drq,
  input  logic              disp_done,
  input  logic              disp_async,
  input  logic              async_cmpl,
  output logic              disp_valid,
  output logic [SLOT_W-1:0] disp_slot,
  output logic              busy_valid,
  output logic [SLOT_W-1:0] busy_slot,
  output logic [NSLOT-1:0]  issue_map
);
  logic              clr_en;
  logic [SLOT_W-1:0] clr_idx;
  logic              park_set;
  logic              park_clr;

  slot_issue_map #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_map (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (issue_wr_en),
    .wr_mask (issue_wr_mask),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .map_q   (issue_map)
  );

  slot_scan_fsm #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .port_reset (port_reset),
    .run_en     (run_en),
    .map_q      (issue_map),
    .dev_busy   (dev_busy),
    .dev_drq    (dev_drq),
    .disp_done  (disp_done),
    .disp_async (disp_async),
    .async_cmpl (async_cmpl),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .park_set   (park_set),
    .park_clr   (park_clr),
    .disp_valid (disp_valid),
    .disp_slot  (disp_slot)
  );

  slot_park_reg #(.SLOT_W(SLOT_W)) u_park (
    .clk          (clk),
    .rst          (rst),
    .park_set     (park_set),
    .park_idx     (disp_slot),
    .park_clr     (park_clr),
    .parked_q     (busy_valid),
    .parked_idx_q (busy_slot)
  );
endmodule

// File: rtl/slot_dispatch_sched_chk.sv
module slot_dispatch_sched_chk #(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input logic              clk,
  input logic              rst,
  input logic              port_reset,
  input logic              run_en,
  input logic              issue_wr_en,
  input logic              dev_busy,
  input logic              dev_drq,
  input logic              disp_valid,
  input logic [SLOT_W-1:0] disp_slot,
  input logic              busy_valid,
  input logic [SLOT_W-1:0] busy_slot,
  input logic [NSLOT-1:0]  issue_map
);
  p_start_gate_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_valid) |-> $past(run_en));

  p_offer_pending_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_valid) |-> issue_map[disp_slot]);

  p_refuse_held_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_valid) |-> (!$past(dev_busy) && !$past(dev_drq)));

  p_park_keeps_bit_r5: assert property (@(posedge clk) disable iff (rst)
    busy_valid |-> issue_map[busy_slot]);

  p_release_clears_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_valid) && !$past(port_reset) && !$past(issue_wr_en))
      |-> !issue_map[$past(busy_slot)]);

  p_reset_unparks_r7: assert property (@(posedge clk) disable iff (rst)
    port_reset |=> !busy_valid);

  p_single_outstanding_r9: assert property (@(posedge clk) disable iff (rst)
    busy_valid |-> !disp_valid);

  p_slot_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && $past(disp_valid)) |-> $stable(disp_slot));
endmodule

bind slot_dispatch_sched slot_dispatch_sched_chk #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .port_reset  (port_reset),
  .run_en      (run_en),
  .issue_wr_en (issue_wr_en),
  .dev_busy    (dev_busy),
  .dev_drq     (dev_drq),
  .disp_valid  (disp_valid),
  .disp_slot   (disp_slot),
  .busy_valid  (busy_valid),
  .busy_slot   (busy_slot),
  .issue_map   (issue_map)
);

// File: tb/test_slot_dispatch_sched.sv
`timescale 1ns/1ps
module test_slot_dispatch_sched;
  localparam int NSLOT  = 32;
  localparam int SLOT_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              port_reset = 1'b0;
  logic              run_en = 1'b0;
  logic              issue_wr_en = 1'b0;
  logic [NSLOT-1:0]  issue_wr_mask = '0;
  logic              dev_busy = 1'b0;
  logic              dev_drq = 1'b0;
  logic              disp_done = 1'b0;
  logic              disp_async = 1'b0;
  logic              async_cmpl = 1'b0;
  logic              disp_valid;
  logic [SLOT_W-1:0] disp_slot;
  logic              busy_valid;
  logic [SLOT_W-1:0] busy_slot;
  logic [NSLOT-1:0]  issue_map;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int eng_delay = 1;
  logic eng_async = 1'b0;
  logic prev_dv = 1'b0;

  always #2 clk = ~clk;

  slot_dispatch_sched #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) i_slot_dispatch_sched (
    .clk(clk), .rst(rst), .port_reset(port_reset), .run_en(run_en),
    .issue_wr_en(issue_wr_en), .issue_wr_mask(issue_wr_mask),
    .dev_busy(dev_busy), .dev_drq(dev_drq), .disp_done(disp_done),
    .disp_async(disp_async), .async_cmpl(async_cmpl),
    .disp_valid(disp_valid), .disp_slot(disp_slot),
    .busy_valid(busy_valid), .busy_slot(busy_slot), .issue_map(issue_map)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: every new offer is popped from the scoreboard (R2, R9).
  always @(negedge clk) begin
    if (!rst && disp_valid && !prev_dv) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 R9 unexpected offer", disp_slot, 32'hFFFF_FFFF);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(disp_slot == SLOT_W'(e), "R2 offer order", disp_slot, e);
      end
    end
    prev_dv <= disp_valid;
  end

  // Engine model: answers an offer after eng_delay cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && disp_valid) begin
        repeat (eng_delay) @(negedge clk);
        disp_done  = 1'b1;
        disp_async = eng_async;
        @(negedge clk);
        disp_done  = 1'b0;
        disp_async = 1'b0;
      end
    end
  end

  task automatic post(input logic [NSLOT-1:0] m);
    @(negedge clk);
    issue_wr_en = 1'b1;
    issue_wr_mask = m;
    @(negedge clk);
    issue_wr_en = 1'b0;
    issue_wr_mask = '0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse_cmpl();
    @(negedge clk);
    async_cmpl = 1'b1;
    @(negedge clk);
    async_cmpl = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(issue_map == '0, "R10 map after reset", issue_map, 0);
    check(!disp_valid && !busy_valid, "R10 outputs after reset",
          {disp_valid, busy_valid}, 0);

    // R1: posted work waits for run_en
    post(32'h0000_000A);
    repeat (20) @(negedge clk);
    check(issue_map == 32'hA, "R1 no scan without run_en", issue_map, 32'hA);

    // R2/R3: ascending, synchronous completion clears
    exp_q.push_back(1); exp_q.push_back(3);
    run_en = 1'b1;
    drain("R2 offers 1,3");
    check(issue_map == '0, "R3 sync done clears bits", issue_map, 0);

    // R8 + R2: merge during a pass; bit behind scan waits for next pass
    eng_delay = 4;
    exp_q.push_back(5); exp_q.push_back(9); exp_q.push_back(12); exp_q.push_back(2);
    post(32'h0000_0220);
    while (!(disp_valid && disp_slot == 5)) @(negedge clk);
    post(32'h0000_1004);
    check(issue_map == 32'h1224, "R8 OR-merge keeps old bits", issue_map, 32'h1224);
    drain("R2 R8 offers 5,9,12,2");
    check(issue_map == '0, "R8 merged bits all served", issue_map, 0);
    eng_delay = 1;

    // R4: busy and drq refuse dispatch
    dev_busy = 1'b1;
    post(32'h0000_0010);
    repeat (30) @(negedge clk);
    check(issue_map == 32'h10, "R4 busy keeps bit", issue_map, 32'h10);
    dev_busy = 1'b0; dev_drq = 1'b1;
    repeat (20) @(negedge clk);
    check(issue_map == 32'h10, "R4 drq keeps bit", issue_map, 32'h10);
    exp_q.push_back(4);
    dev_drq = 1'b0;
    drain("R4 offer after release");
    check(issue_map == '0, "R4 served", issue_map, 0);

    // R5/R6/R9: asynchronous park and release
    eng_async = 1'b1;
    exp_q.push_back(7);
    post(32'h0000_0080);
    drain("R5 offer 7");
    eng_async = 1'b0;
    check(busy_valid == 1'b1, "R5 parked", busy_valid, 1);
    check(busy_slot == 7, "R5 parked slot", busy_slot, 7);
    check(issue_map == 32'h80, "R5 bit kept", issue_map, 32'h80);
    post(32'h0000_0008);
    repeat (20) @(negedge clk);
    check(issue_map == 32'h88 && !disp_valid, "R9 no offer while parked", issue_map, 32'h88);
    dev_busy = 1'b1;
    pulse_cmpl();
    repeat (5) @(negedge clk);
    check(busy_valid && issue_map == 32'h88, "R6 cmpl ignored while busy",
          {busy_valid, issue_map}, {1'b1, 32'h88});
    dev_busy = 1'b0;
    exp_q.push_back(3);
    pulse_cmpl();
    drain("R6 rescan offers 3");
    check(!busy_valid, "R6 park emptied", busy_valid, 0);
    check(issue_map == '0, "R6 parked bit cleared", issue_map, 0);

    // R7: port reset unparks, keeps bits
    eng_async = 1'b1;
    exp_q.push_back(6);
    post(32'h0000_0040);
    drain("R7 offer 6");
    eng_async = 1'b0;
    check(busy_valid == 1'b1, "R7 parked before reset", busy_valid, 1);
    dev_busy = 1'b1;
    @(negedge clk); port_reset = 1'b1;
    @(negedge clk); port_reset = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_valid, "R7 reset unparks", busy_valid, 0);
    check(issue_map == 32'h40, "R7 bits kept", issue_map, 32'h40);
    exp_q.push_back(6);
    dev_busy = 1'b0;
    drain("R7 reoffer 6");
    check(issue_map == '0, "R7 served", issue_map, 0);

    // R2 boundary: slots 0 and 31
    exp_q.push_back(0); exp_q.push_back(31);
    post(32'h8000_0001);
    drain("R2 offers 0,31");
    check(issue_map == '0, "R2 edge slots served", issue_map, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule